// File: doc/BRIEF.md
# Firmware Glue Register Peripheral

This is a small memory-mapped slave that gives boot firmware a handful of system services behind one 32-byte window. Firmware can request a halt and leave an exit code. It can learn which processor is issuing the access and how many processors the system has. It can drive any processor's level-sensitive interrupt line with a single store. A one-character console path runs in each direction: incoming characters arrive on a valid/ready stream, and outgoing characters leave on another.

The bus side is a single-cycle request port with a 32-bit data path, four byte enables and a requester-ID input. Writes take effect on the clock edge that samples the request. Read data is registered and comes back one cycle later, flagged by `bus_rvalid`. Only address bits [4:2] select a register, so the window repeats every 32 bytes. Each register sits in byte lane 0 of its word. The one exception is the interrupt level, which sits in lane 1 of the interrupt word.

Word map (byte offset within the window):

- 0: exit. Write only.
- 4: requester index. Read only.
- 8: interrupt port in lane 0, interrupt level in lane 1. Write only.
- 12: processor count. Read only.
- 16: console input byte.
- 20: console input status.
- 24: console output byte.
- 28: console output status.

Top module: `fw_glue_regs`

## Requirements
- R1: After reset, reads return 0 from the input byte (16) and the output byte (24), and 1 from the output status (28). All interrupt lines are low, `halt_req` is low and `cout_valid` is low.
- R2: Only address bits [4:2] select a register. An access at any offset plus a multiple of 32 behaves exactly like the access at that offset.
- R3: A read returns the register byte in bits [7:0], with bits [31:8] zero. Reads of the write-only words (0 and 8) return 0. `bus_rvalid` is high in the cycle after each read request.
- R4: A write acts on a register only when `bus_be[0]` is set, and it uses only `bus_wdata[7:0]`. The other lanes are ignored, apart from the interrupt level described in R7.
- R5: A write to offset 0 sets `halt_req`, which stays high until reset, and loads the written byte into `exit_code`. Later writes to offset 0 replace the code.
- R6: A read of offset 4 returns `bus_src_id`. A read of offset 12 returns NUM_CPU.
- R7: A write to offset 8 with `bus_be[1:0]`=11 drives interrupt line P (P = `bus_wdata[7:0]`) high if `bus_wdata[15:8]` is nonzero, and low otherwise. Every other line keeps its level.
- R8: A write to offset 8 with `bus_be[1]` clear drives line P low. A port value P of NUM_CPU or above changes no line.
- R9: A read of offset 20 samples the console input. If `cin_valid` is high, it returns 1, pulses `cin_ready` in that cycle and loads `cin_data` into the input byte. Otherwise it returns 0 and clears the input byte.
- R10: Writes to offset 16 and offset 28 overwrite the stored byte, and the new value reads back. A write to offset 20 leaves nothing observable, because every status read resamples the console.
- R11: A write to offset 24 while no byte is pending sets `cout_valid` with `cout_data` equal to the written byte, and the byte reads back at offset 24. Offset 28 reads 0 until the sink accepts the byte (`cout_valid` and `cout_ready` both high), then reads 1.
- R12: While an output byte is pending, further writes to offset 24 are dropped, and `cout_data` stays stable until acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] decoded |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_src_id | input | ID_W | Index of the requesting processor |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| halt_req | output | 1 | Sticky halt request |
| exit_code | output | 8 | Last byte written to the exit word |
| irq_lines | output | NUM_CPU | Per-processor level interrupt lines |
| cin_valid | input | 1 | Console input character available |
| cin_data | input | 8 | Console input character |
| cin_ready | output | 1 | Console input character consumed |
| cout_valid | output | 1 | Console output character pending |
| cout_data | output | 8 | Console output character |
| cout_ready | input | 1 | Console sink accepts the character |

## Verification
The bench targets the interrupt word in three ways: a one-lane store, which must drive the line low rather than keep the stale level; an out-of-range port, which a design that truncated the index would wrap onto a real line; and a store without lane 0, which must be dropped. It polls the input status with and without a character present. A design that latched instead of sampling would report a stale 1 or keep an old byte. It stalls the console sink and then writes a second byte. A design without back-pressure handling would report status 1 too early or swap the held byte. It also checks aliased addresses and masked lanes, where a decoder using too many bits or ignoring byte enables would return wrong data or corrupt a register.

// File: rtl/fwg_pkg.sv
// Package: shared constants and types for the firmware glue register block.
// Assumes a 32-bit bus with four byte lanes and a 32-byte decode window.
package fwg_pkg;

    localparam int LANE_W = 8;
    localparam int BUS_W  = 32;
    localparam int BE_W   = BUS_W / LANE_W;
    localparam int OFS_W  = 5;

    // Word index inside the window (address bits [4:2]); the order is the map.
    typedef enum logic [2:0] {
        IDX_EXIT     = 3'd0,
        IDX_CPUID    = 3'd1,
        IDX_IRQ      = 3'd2,
        IDX_NCPU     = 3'd3,
        IDX_IN_DATA  = 3'd4,
        IDX_IN_STAT  = 3'd5,
        IDX_OUT_DATA = 3'd6,
        IDX_OUT_STAT = 3'd7
    } reg_idx_t;

    // One strobe per register side effect; at most one is high per cycle.
    typedef struct packed {
        logic exit_w;
        logic irq_w;
        logic in_data_w;
        logic in_stat_w;
        logic out_data_w;
        logic out_stat_w;
        logic in_poll;
    } strobe_t;

endpackage

// File: rtl/fwg_decode.sv
// Module: fwg_decode
// Turns one bus request into a read index and a set of side-effect strobes.
// Assumes: only offset bits [4:2] matter; a write reaches a register only
// when byte lane 0 is enabled. A read of the input-status word is a poll.
module fwg_decode
    import fwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [OFS_W-1:0] ofs,
    input  logic             be_lane0,
    output reg_idx_t         idx,
    output strobe_t          stb
);

    logic wr_ok;
    logic rd_ok;
    logic [1:0] unused_ofs_lo;

    assign unused_ofs_lo = ofs[1:0];

    // Select the word from the upper offset bits.
    always_comb begin
        idx = reg_idx_t'(ofs[OFS_W-1:2]);
    end

    // Qualify the request as a usable write or as a read.
    always_comb begin
        wr_ok = req && we && be_lane0;
        rd_ok = req && !we;
    end

    // Raise the strobe of the addressed register.
    always_comb begin
        stb            = '0;
        stb.exit_w     = wr_ok && (idx == IDX_EXIT);
        stb.irq_w      = wr_ok && (idx == IDX_IRQ);
        stb.in_data_w  = wr_ok && (idx == IDX_IN_DATA);
        stb.in_stat_w  = wr_ok && (idx == IDX_IN_STAT);
        stb.out_data_w = wr_ok && (idx == IDX_OUT_DATA);
        stb.out_stat_w = wr_ok && (idx == IDX_OUT_STAT);
        stb.in_poll    = rd_ok && (idx == IDX_IN_STAT);
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb)) else $error("decode raised more than one strobe"); // R4

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (stb == '0)) else $error("strobe without request"); // R4

endmodule

// File: rtl/fwg_irq_bank.sv
// Module: fwg_irq_bank
// Holds one level-sensitive interrupt line per processor.
// Assumes: a port value selects the line with the same index; values at or
// above NUM_CPU match no line. The level is nonzero-means-high, and it is
// forced to zero when the level lane was not written.
module fwg_irq_bank #(
    parameter int NUM_CPU = 4,
    parameter int PORT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] port,
    input  logic              level_en,
    input  logic [PORT_W-1:0] level,
    output logic [NUM_CPU-1:0] irq_o
);

    logic drive_high;

    // Resolve the written level into a single bit.
    always_comb begin
        drive_high = level_en && (level != '0);
    end

    for (genvar gi = 0; gi < NUM_CPU; gi++) begin : g_line
        // Update this line only when the write names its index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_o[gi] <= 1'b0;
            end else if (wr_en && (port == PORT_W'(gi))) begin
                irq_o[gi] <= drive_high;
            end
        end
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irq_o)) else $error("line moved without a write"); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($countones(irq_o ^ $past(irq_o)) <= 1))
        else $error("one write changed several lines"); // R7

    AST_IRQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (port >= PORT_W'(NUM_CPU))) |=> $stable(irq_o))
        else $error("out-of-range port moved a line"); // R8

endmodule

// File: rtl/fwg_console.sv
// Module: fwg_console
// One-character console input buffer and a single-entry output port.
// Assumes: a poll (status read) samples cin_valid in the same cycle and
// consumes the character; an output byte is held on cout_data until the
// sink accepts it, and new output writes are dropped while one is held.
module fwg_console
    import fwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll,
    input  logic              in_data_w,
    input  logic              out_data_w,
    input  logic              out_stat_w,
    input  logic [LANE_W-1:0] wbyte,
    input  logic              cin_valid,
    input  logic [LANE_W-1:0] cin_data,
    output logic              cin_ready,
    output logic              cout_valid,
    output logic [LANE_W-1:0] cout_data,
    input  logic              cout_ready,
    output logic [LANE_W-1:0] in_data_q,
    output logic [LANE_W-1:0] in_stat_rd,
    output logic [LANE_W-1:0] out_stat_rd
);

    logic              pending;
    logic [LANE_W-1:0] out_buf;
    logic [LANE_W-1:0] out_stat;
    logic              accept;

    // Consume the input character only when a poll sees one.
    always_comb begin
        cin_ready  = poll && cin_valid;
        in_stat_rd = {{(LANE_W-1){1'b0}}, cin_valid};
    end

    // Input buffer: a poll loads it or clears it; software may overwrite it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_data_q <= '0;
        end else if (poll) begin
            in_data_q <= cin_valid ? cin_data : '0;
        end else if (in_data_w) begin
            in_data_q <= wbyte;
        end
    end

    // Handshake completes when the sink takes the held byte.
    always_comb begin
        accept = pending && cout_ready;
    end

    // Output byte and pending flag: load on an idle write, clear on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            out_buf <= '0;
        end else if (out_data_w && !pending) begin
            pending <= 1'b1;
            out_buf <= wbyte;
        end else if (accept) begin
            pending <= 1'b0;
        end
    end

    // Output status byte: set by a sent byte, overwritable by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_stat <= LANE_W'(1);
        end else if (out_data_w && !pending) begin
            out_stat <= LANE_W'(1);
        end else if (out_stat_w) begin
            out_stat <= wbyte;
        end
    end

    // Expose stream and read-back values.
    always_comb begin
        cout_valid  = pending;
        cout_data   = out_buf;
        out_stat_rd = pending ? '0 : out_stat;
    end

    AST_COUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cout_valid && !cout_ready) |=> (cout_valid && $stable(cout_data)))
        else $error("held output byte changed"); // R12

    AST_POLL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        poll |=> (in_data_q == ($past(cin_valid) ? $past(cin_data) : '0)))
        else $error("poll did not refresh the input byte"); // R9

    AST_CIN_READY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        cin_ready |-> (poll && cin_valid)) else $error("stray cin_ready"); // R9

    AST_STAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cout_valid |-> (out_stat_rd == '0)) else $error("status 1 while busy"); // R11

endmodule

// File: rtl/fw_glue_regs.sv
// Module: fw_glue_regs (top)
// Firmware glue register window: exit/halt, requester index, processor
// count, per-processor interrupt levels and a byte-wide console.
// Assumes: one-cycle requests; writes land on the sampling edge; read data
// is registered and flagged by bus_rvalid one cycle later; NUM_CPU <= 255.
module fw_glue_regs
    import fwg_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    parameter int ID_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    input  logic [ID_W-1:0]    bus_src_id,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               halt_req,
    output logic [7:0]         exit_code,
    output logic [NUM_CPU-1:0] irq_lines,
    input  logic               cin_valid,
    input  logic [7:0]         cin_data,
    output logic               cin_ready,
    output logic               cout_valid,
    output logic [7:0]         cout_data,
    input  logic               cout_ready
);

    localparam int UPPER_W = BUS_W - LANE_W;

    reg_idx_t          idx;
    strobe_t           stb;
    logic [LANE_W-1:0] wbyte;
    logic [LANE_W-1:0] level_byte;
    logic [LANE_W-1:0] in_data_q;
    logic [LANE_W-1:0] in_stat_rd;
    logic [LANE_W-1:0] out_stat_rd;
    logic [LANE_W-1:0] rd_byte;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[ADDR_W-1:OFS_W], bus_wdata[31:16], bus_be[3:2], stb.in_stat_w};

    // Pick out the lane-0 byte and the interrupt level lane.
    always_comb begin
        wbyte      = bus_wdata[LANE_W-1:0];
        level_byte = bus_wdata[2*LANE_W-1:LANE_W];
    end

    fwg_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .we       (bus_we),
        .ofs      (bus_addr[OFS_W-1:0]),
        .be_lane0 (bus_be[0]),
        .idx      (idx),
        .stb      (stb)
    );

    fwg_irq_bank #(
        .NUM_CPU (NUM_CPU),
        .PORT_W  (LANE_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (stb.irq_w),
        .port     (wbyte),
        .level_en (bus_be[1]),
        .level    (level_byte),
        .irq_o    (irq_lines)
    );

    fwg_console u_console (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll        (stb.in_poll),
        .in_data_w   (stb.in_data_w),
        .out_data_w  (stb.out_data_w),
        .out_stat_w  (stb.out_stat_w),
        .wbyte       (wbyte),
        .cin_valid   (cin_valid),
        .cin_data    (cin_data),
        .cin_ready   (cin_ready),
        .cout_valid  (cout_valid),
        .cout_data   (cout_data),
        .cout_ready  (cout_ready),
        .in_data_q   (in_data_q),
        .in_stat_rd  (in_stat_rd),
        .out_stat_rd (out_stat_rd)
    );

    // Sticky halt request with the most recent exit code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_req  <= 1'b0;
            exit_code <= '0;
        end else if (stb.exit_w) begin
            halt_req  <= 1'b1;
            exit_code <= wbyte;
        end
    end

    // Choose the byte a read of the addressed word returns.
    always_comb begin
        unique case (idx)
            IDX_CPUID:    rd_byte = LANE_W'(bus_src_id);
            IDX_NCPU:     rd_byte = LANE_W'(NUM_CPU);
            IDX_IN_DATA:  rd_byte = in_data_q;
            IDX_IN_STAT:  rd_byte = in_stat_rd;
            IDX_OUT_DATA: rd_byte = cout_data;
            IDX_OUT_STAT: rd_byte = out_stat_rd;
            default:      rd_byte = '0;
        endcase
    end

    // Register the read response with the upper lanes zeroed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            bus_rdata  <= (bus_req && !bus_we) ? {{UPPER_W{1'b0}}, rd_byte} : '0;
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> halt_req) else $error("halt request dropped"); // R5

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid) else $error("missing read response"); // R3

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[31:8] == '0)) else $error("upper lanes nonzero"); // R3

    AST_EXIT_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we) |=> $stable(exit_code)) else $error("exit code moved"); // R5

endmodule

// File: tb/fw_glue_regs_tb.sv
module fw_glue_regs_tb;

    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_src_id = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        halt_req;
    logic [7:0]  exit_code;
    logic [NCPU-1:0] irq_lines;
    logic        cin_valid = 1'b0;
    logic [7:0]  cin_data = '0;
    logic        cin_ready;
    logic        cout_valid;
    logic [7:0]  cout_data;
    logic        cout_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fw_glue_regs #(.NUM_CPU(NCPU), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_src_id(bus_src_id), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .halt_req(halt_req), .exit_code(exit_code), .irq_lines(irq_lines),
        .cin_valid(cin_valid), .cin_data(cin_data), .cin_ready(cin_ready),
        .cout_valid(cout_valid), .cout_data(cout_data), .cout_ready(cout_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
        @(negedge clk);
        bus_req = 1'b0; bus_be = '0;
        v = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {28'b0, irq_lines}, 32'h0);
        chk("R1 halt", {31'b0, halt_req}, 32'h0);
        chk("R1 cout_valid", {31'b0, cout_valid}, 32'h0);
        rd(12'h010, v); chk("R1 in byte", v, 32'h0);
        rd(12'h018, v); chk("R1 out byte", v, 32'h0);
        rd(12'h01C, v); chk("R1 out status", v, 32'h1);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        bus_src_id = 2'd3;
        rd(12'h004, v); chk("R6 cpu id", v, 32'h3);
        bus_src_id = 2'd1;
        rd(12'h104, v); chk("R2 R6 aliased cpu id", v, 32'h1);
        rd(12'h00C, v); chk("R6 count", v, NCPU);
        rd(12'h02C, v); chk("R2 aliased count", v, NCPU);
        rd(12'h000, v); chk("R3 exit word reads 0", v, 32'h0);
        rd(12'h008, v); chk("R3 irq word reads 0", v, 32'h0);
    endtask

    task automatic t_lanes();
        logic [31:0] v;
        wr(12'h010, 4'hF, 32'h1122_3344);
        rd(12'h010, v); chk("R3 R10 in byte lane0", v, 32'h44);
        wr(12'h010, 4'hE, 32'hAABB_CC99);
        rd(12'h010, v); chk("R4 lane0 off ignored", v, 32'h44);
        wr(12'h030, 4'h1, 32'hFFFF_FF5A);
        rd(12'h010, v); chk("R2 R4 aliased write", v, 32'h5A);
    endtask

    task automatic t_halt();
        wr(12'h000, 4'hF, 32'h0000_772A);
        chk("R5 halt set", {31'b0, halt_req}, 32'h1);
        chk("R5 exit code", {24'b0, exit_code}, 32'h2A);
        wr(12'h020, 4'h1, 32'h0000_0007);
        chk("R5 halt stays", {31'b0, halt_req}, 32'h1);
        chk("R5 code replaced", {24'b0, exit_code}, 32'h07);
    endtask

    task automatic t_irq();
        wr(12'h008, 4'h3, 32'h0000_0102);
        chk("R7 line2 high", {28'b0, irq_lines}, 32'h4);
        wr(12'h008, 4'hF, 32'h0000_0301);
        chk("R7 line1 high, line2 held", {28'b0, irq_lines}, 32'h6);
        wr(12'h008, 4'h1, 32'h0000_0502);
        chk("R8 one-byte store lowers line2", {28'b0, irq_lines}, 32'h2);
        wr(12'h008, 4'h3, 32'h0000_0104);
        chk("R8 port out of range", {28'b0, irq_lines}, 32'h2);
        wr(12'h008, 4'h3, 32'h0000_0180);
        chk("R8 big port no wrap", {28'b0, irq_lines}, 32'h2);
        wr(12'h008, 4'h2, 32'h0000_0100);
        chk("R4 no port lane ignored", {28'b0, irq_lines}, 32'h2);
        wr(12'h008, 4'h3, 32'h0000_0001);
        chk("R7 level zero lowers", {28'b0, irq_lines}, 32'h0);
    endtask

    task automatic t_input();
        logic [31:0] v;
        logic seen_ready;
        cin_valid = 1'b1; cin_data = 8'h61;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'h014; bus_be = 4'hF;
        #1 seen_ready = cin_ready;
        @(negedge clk);
        bus_req = 1'b0; bus_be = '0;
        v = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
        chk("R9 status with char", v, 32'h1);
        chk("R9 cin_ready pulse", {31'b0, seen_ready}, 32'h1);
        cin_valid = 1'b0;
        #1 chk("R9 cin_ready idle", {31'b0, cin_ready}, 32'h0);
        rd(12'h010, v); chk("R9 byte loaded", v, 32'h61);
        wr(12'h014, 4'h1, 32'h0000_0009);
        rd(12'h014, v); chk("R9 R10 status resampled", v, 32'h0);
        rd(12'h010, v); chk("R9 byte cleared", v, 32'h0);
    endtask

    task automatic t_output();
        logic [31:0] v;
        cout_ready = 1'b0;
        wr(12'h018, 4'h1, 32'h0000_0041);
        chk("R11 valid", {31'b0, cout_valid}, 32'h1);
        chk("R11 data", {24'b0, cout_data}, 32'h41);
        rd(12'h01C, v); chk("R11 status busy", v, 32'h0);
        rd(12'h018, v); chk("R11 readback", v, 32'h41);
        wr(12'h018, 4'h1, 32'h0000_0042);
        chk("R12 held data", {24'b0, cout_data}, 32'h41);
        chk("R12 still valid", {31'b0, cout_valid}, 32'h1);
        @(negedge clk); cout_ready = 1'b1;
        @(negedge clk); cout_ready = 1'b0;
        chk("R11 accepted", {31'b0, cout_valid}, 32'h0);
        rd(12'h01C, v); chk("R11 status after accept", v, 32'h1);
        rd(12'h018, v); chk("R12 second byte dropped", v, 32'h41);
        wr(12'h01C, 4'h1, 32'h0000_0000);
        rd(12'h01C, v); chk("R10 out status overwrite 0", v, 32'h0);
        wr(12'h01C, 4'hF, 32'h0000_0005);
        rd(12'h01C, v); chk("R10 out status overwrite 5", v, 32'h5);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_lanes();
        t_halt();
        t_irq();
        t_input();
        t_output();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule